// File: doc/BRIEF.md
# Package Deep-Sleep Controller with Stepwise Cache Drain

This block sequences a multi-core package into and out of its deepest sleep state. When every core reports the deepest core sleep state, the controller empties the last-level cache one group of ways at a time. For each group it raises a flush request and waits for a completion pulse before it turns those ways off. Only when no way is left enabled does it declare package sleep and block coherence snoops. The number of ways in a group is sampled once for each separate entry attempt.

A wake event, or any core leaving the deepest state, takes the package out of sleep or aborts a drain in progress. The cache does not come back at once. The ways stay off until no core has been in either deep core state for a programmed number of consecutive cycles. After that they are turned back on a few at a time, at a programmed interval, until all are enabled. Ways are numbered 0 to NUM_WAYS-1. Draining removes the highest enabled ways first, and refilling restores the lowest disabled ways first.

Top module: `pkg_sleep_ctrl`

## Requirements
- R1: After reset every way is enabled, no flush is requested, and both the package-sleep and the snoop-block outputs are low.
- R2: A drain starts only in a cycle in which every core reports the deepest state and no wake event is present. Package sleep is indicated only once the way-enable mask is all zero.
- R3: Each drain step requests a flush of the highest min(N, enabled) enabled ways. Those ways stay enabled until a flush-done pulse arrives, and they are disabled at the edge that samples that pulse.
- R4: The group size N is captured when an entry attempt begins and is held for the whole attempt. Later changes to the input have no effect until the next attempt. A value of 0 acts as 1.
- R5: The snoop-block and package-sleep outputs are high together, in exactly the cycles the package is asleep, and no flush is requested then.
- R6: A wake event, or any core leaving the deepest state, ends package sleep at the next edge with every way still disabled.
- R7: Ways are re-enabled only after H consecutive cycles, counted from exit, in which no core reports either deep state. The first way group returns at the edge that ends the H-th such cycle. H = 0 acts as 1.
- R8: A cycle in which any core reports either deep state during the hold-off restarts the count from zero.
- R9: Refill adds E ways per step (0 acts as 1), one step every I cycles (0 acts as 1), and saturates at NUM_WAYS. At full count the controller returns to the awake, fully enabled state.
- R10: A core leaving the deepest state during a drain aborts it without package sleep. Ways already disabled stay off until the hold-off of R7 has expired.
- R11: If a flush-done pulse and an abort fall in the same cycle, the flushed group is disabled and the drain is still aborted.
- R12: An entry attempt during hold-off or refill drains from the current way count, and enters package sleep directly at the next edge when that count is already zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_deepest_i | input | NUM_CORES | Per-core flag: core in deepest sleep state |
| core_deep_i | input | NUM_CORES | Per-core flag: core in the next deepest sleep state |
| wake_i | input | 1 | Break event asking the package to wake |
| shrink_step_i | input | CNT_W | Ways drained per step for this entry |
| flush_done_i | input | 1 | One-cycle pulse: requested flush finished |
| holdoff_cyc_i | input | HOLD_W | Hold-off length in cycles |
| grow_step_i | input | CNT_W | Ways re-enabled per refill step |
| grow_intv_i | input | INTV_W | Cycles between refill steps |
| way_en_o | output | NUM_WAYS | Cache way-enable mask |
| flush_req_o | output | 1 | Flush request for the ways in flush_ways_o |
| flush_ways_o | output | NUM_WAYS | Ways targeted by the current flush |
| pkg_sleep_o | output | 1 | Package is in the deepest sleep state |
| snoop_block_o | output | 1 | Coherence snoops must not be forwarded |

## Verification
A flush completion and a core waking can land in the same cycle. The bench provokes this by raising the done pulse and clearing the deepest-state flags on the same falling edge. The cycle after, it expects the flushed group gone from the way mask, no flush request and no package sleep. A second collision is a deep-state report that arrives one cycle before the hold-off would have expired. There the bench checks that the mask stays unchanged for the whole restarted count and that refill begins exactly H clean cycles later.

// File: rtl/pslp_pkg.sv
package pslp_pkg;

  typedef enum logic [2:0] {
    PS_AWAKE = 3'd0,
    PS_DRAIN = 3'd1,
    PS_SLEEP = 3'd2,
    PS_HOLD  = 3'd3,
    PS_GROW  = 3'd4
  } pslp_state_e;

endpackage

// File: rtl/pslp_cycle_timer.sv
module pslp_cycle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic [W-1:0] lim_i,
  output logic         hit_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_eff;
  logic [W:0]   cnt_nxt;

  always_comb begin
    lim_eff = (lim_i == '0) ? W'(1) : lim_i;
    cnt_nxt = {1'b0, cnt_q} + (W+1)'(1);
    hit_o   = run_i && !clr_i && (cnt_nxt >= {1'b0, lim_eff});
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (hit_o)      cnt_q <= '0;
    else if (run_i)      cnt_q <= cnt_nxt[W-1:0];
  end

endmodule

// File: rtl/pslp_way_track.sv
module pslp_way_track #(
  parameter int NUM_WAYS = 16,
  parameter int CNT_W    = $clog2(NUM_WAYS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    step_i,
  input  logic                dec_i,
  input  logic                inc_i,
  input  logic [CNT_W-1:0]    inc_amt_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [CNT_W-1:0]    grp_o,
  output logic                full_after_inc_o,
  output logic [NUM_WAYS-1:0] mask_o,
  output logic [NUM_WAYS-1:0] top_mask_o
);

  localparam logic [CNT_W:0] FULL = (CNT_W+1)'(NUM_WAYS);

  function automatic logic [NUM_WAYS-1:0] low_ways(input logic [CNT_W-1:0] n);
    logic [NUM_WAYS-1:0] m;
    for (int i = 0; i < NUM_WAYS; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > FULL) ? FULL[CNT_W-1:0] : s[CNT_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] min_cnt(input logic [CNT_W-1:0] a,
                                                input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] grown;

  always_comb begin
    grp_o            = min_cnt(step_i, cnt_q);
    grown            = sat_add(cnt_q, inc_amt_i);
    full_after_inc_o = ({1'b0, grown} == FULL);
    mask_o           = low_ways(cnt_q);
    top_mask_o       = low_ways(cnt_q) & ~low_ways(cnt_q - grp_o);
    cnt_o            = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= FULL[CNT_W-1:0];
    else if (dec_i)  cnt_q <= cnt_q - grp_o;
    else if (inc_i)  cnt_q <= grown;
  end

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_q} <= FULL);

  assert_dec_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |=> ($countones(mask_o) == $past($countones(mask_o)) - $past(int'(grp_o))));

endmodule

// File: rtl/pkg_sleep_ctrl.sv
module pkg_sleep_ctrl
  import pslp_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_WAYS  = 16,
  parameter int HOLD_W    = 16,
  parameter int INTV_W    = 8,
  parameter int CNT_W     = $clog2(NUM_WAYS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] core_deepest_i,
  input  logic [NUM_CORES-1:0] core_deep_i,
  input  logic                 wake_i,
  input  logic [CNT_W-1:0]     shrink_step_i,
  input  logic                 flush_done_i,
  input  logic [HOLD_W-1:0]    holdoff_cyc_i,
  input  logic [CNT_W-1:0]     grow_step_i,
  input  logic [INTV_W-1:0]    grow_intv_i,
  output logic [NUM_WAYS-1:0]  way_en_o,
  output logic                 flush_req_o,
  output logic [NUM_WAYS-1:0]  flush_ways_o,
  output logic                 pkg_sleep_o,
  output logic                 snoop_block_o
);

  pslp_state_e      state_q, state_d;
  logic [CNT_W-1:0] step_q;
  logic [CNT_W-1:0] step_pick;
  logic [CNT_W-1:0] grow_amt;
  logic [CNT_W-1:0] way_cnt;
  logic [CNT_W-1:0] grp;
  logic             full_after_inc;

  // named events for the assertions
  logic all_deepest;
  logic any_deep;
  logic entry_ok;
  logic abort_ev;
  logic hold_hit;
  logic intv_hit;
  logic load_step;
  logic dec_ev;
  logic inc_ev;

  always_comb begin
    all_deepest = &core_deepest_i;
    any_deep    = |(core_deepest_i | core_deep_i);
    entry_ok    = all_deepest && !wake_i;
    abort_ev    = (state_q == PS_DRAIN) && !entry_ok;
    step_pick   = (shrink_step_i == '0) ? CNT_W'(1) : shrink_step_i;
    grow_amt    = (grow_step_i == '0) ? CNT_W'(1) : grow_step_i;
  end

  always_comb begin
    state_d   = state_q;
    load_step = 1'b0;
    dec_ev    = 1'b0;
    inc_ev    = 1'b0;
    unique case (state_q)
      PS_AWAKE: begin
        if (entry_ok) begin
          load_step = 1'b1;
          state_d   = PS_DRAIN;
        end
      end
      PS_DRAIN: begin
        dec_ev = flush_done_i;
        if (!entry_ok)                         state_d = PS_HOLD;
        else if (flush_done_i && grp == way_cnt) state_d = PS_SLEEP;
      end
      PS_SLEEP: begin
        if (!entry_ok) state_d = PS_HOLD;
      end
      PS_HOLD, PS_GROW: begin
        if (entry_ok) begin
          if (way_cnt == '0) state_d = PS_SLEEP;
          else begin
            load_step = 1'b1;
            state_d   = PS_DRAIN;
          end
        end else if (state_q == PS_GROW && any_deep) begin
          state_d = PS_HOLD;
        end else if ((state_q == PS_HOLD && hold_hit) ||
                     (state_q == PS_GROW && intv_hit)) begin
          inc_ev  = 1'b1;
          state_d = full_after_inc ? PS_AWAKE : PS_GROW;
        end
      end
      default: state_d = PS_AWAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PS_AWAKE;
      step_q  <= CNT_W'(1);
    end else begin
      state_q <= state_d;
      if (load_step) step_q <= step_pick;
    end
  end

  pslp_way_track #(
    .NUM_WAYS (NUM_WAYS),
    .CNT_W    (CNT_W)
  ) u_ways (
    .clk              (clk),
    .rst_n            (rst_n),
    .step_i           (step_q),
    .dec_i            (dec_ev),
    .inc_i            (inc_ev),
    .inc_amt_i        (grow_amt),
    .cnt_o            (way_cnt),
    .grp_o            (grp),
    .full_after_inc_o (full_after_inc),
    .mask_o           (way_en_o),
    .top_mask_o       (flush_ways_o)
  );

  pslp_cycle_timer #(.W(HOLD_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (state_q != PS_HOLD || any_deep),
    .run_i (state_q == PS_HOLD),
    .lim_i (holdoff_cyc_i),
    .hit_o (hold_hit)
  );

  pslp_cycle_timer #(.W(INTV_W)) u_intv (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (state_q != PS_GROW || any_deep),
    .run_i (state_q == PS_GROW),
    .lim_i (grow_intv_i),
    .hit_o (intv_hit)
  );

  assign flush_req_o   = (state_q == PS_DRAIN);
  assign pkg_sleep_o   = (state_q == PS_SLEEP);
  assign snoop_block_o = (state_q == PS_SLEEP);

  assert_sleep_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pkg_sleep_o |-> (way_en_o == '0));

  assert_snoop_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_block_o |-> (way_cnt == '0) && (flush_ways_o == '0));

  assert_flush_inside_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req_o |-> (flush_ways_o != '0) && ((flush_ways_o & ~way_en_o) == '0));

  assert_no_early_grow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_HOLD && !hold_hit) |=> (way_cnt == $past(way_cnt)));

  assert_grow_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (way_cnt > $past(way_cnt)) |-> ((way_cnt - $past(way_cnt)) <= $past(grow_amt)));

  assert_abort_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_ev && !flush_done_i) |=> (way_cnt == $past(way_cnt)) && !pkg_sleep_o);

endmodule

// File: tb/pkg_sleep_ctrl_tb.sv
`timescale 1ns/1ps
module pkg_sleep_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  c_deepest, c_deep;
  logic        wake, fdone;
  logic [4:0]  sstep, gstep;
  logic [15:0] hold;
  logic [7:0]  intv;
  logic [15:0] way_en, fways;
  logic        freq, psleep, sblock;

  int vecs  = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pkg_sleep_ctrl u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .core_deepest_i (c_deepest),
    .core_deep_i    (c_deep),
    .wake_i         (wake),
    .shrink_step_i  (sstep),
    .flush_done_i   (fdone),
    .holdoff_cyc_i  (hold),
    .grow_step_i    (gstep),
    .grow_intv_i    (intv),
    .way_en_o       (way_en),
    .flush_req_o    (freq),
    .flush_ways_o   (fways),
    .pkg_sleep_o    (psleep),
    .snoop_block_o  (sblock)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [15:0] lowm(input int n);
    return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
  endfunction

  task automatic test_reset();
    chk("R1 ways", way_en, 16'hFFFF);
    chk("R1 flush", freq, 0);
    chk("R1 sleep", psleep, 0);
    chk("R1 snoop", sblock, 0);
  endtask

  task automatic pulse_done();
    fdone = 1; tick(); fdone = 0;
  endtask

  task automatic test_drain_and_refill();
    sstep = 5; c_deepest = 4'hF; tick();
    chk("R2 flush start", freq, 1);
    chk("R3 first group", fways, 16'hF800);
    chk("R3 held until done", way_en, 16'hFFFF);
    tick();
    chk("R3 still waiting", way_en, 16'hFFFF);
    pulse_done();
    chk("R3 after done", way_en, 16'h07FF);
    chk("R3 next group", fways, 16'h07C0);
    sstep = 2;
    pulse_done();
    chk("R4 step held", fways, 16'h003E);
    pulse_done();
    chk("R3 remainder", fways, 16'h0001);
    chk("R2 not asleep yet", psleep, 0);
    pulse_done();
    chk("R2 empty", way_en, 16'h0000);
    chk("R5 sleep", psleep, 1);
    chk("R5 snoop", sblock, 1);
    chk("R5 no flush", freq, 0);
    hold = 10; gstep = 3; intv = 4;
    wake = 1; c_deepest = 0; tick(); wake = 0;
    chk("R6 exit", psleep, 0);
    chk("R6 snoop off", sblock, 0);
    chk("R6 ways off", way_en, 16'h0000);
    for (int k = 1; k < 10; k++) tick();
    chk("R7 before expiry", way_en, 16'h0000);
    tick();
    chk("R7 first refill", way_en, 16'h0007);
    for (int n = 6; n <= 18; n += 3) begin
      for (int k = 1; k < 4; k++) tick();
      chk("R9 interval hold", way_en, lowm(n - 3));
      tick();
      chk("R9 refill step", way_en, lowm(n));
    end
    chk("R9 awake", freq, 0);
  endtask

  task automatic test_abort();
    sstep = 0; c_deepest = 4'hF; tick();
    chk("R4 zero as one", fways, 16'h8000);
    pulse_done();
    chk("R3 one way off", way_en, 16'h7FFF);
    hold = 3; gstep = 5; intv = 1;
    c_deepest = 4'b1110; tick(); c_deepest = 0;
    chk("R10 abort no flush", freq, 0);
    chk("R10 abort no sleep", psleep, 0);
    chk("R10 ways kept off", way_en, 16'h7FFF);
    tick(); tick();
    chk("R10 off during hold", way_en, 16'h7FFF);
    tick();
    chk("R9 saturate", way_en, 16'hFFFF);
    tick();
    chk("R9 stays full", way_en, 16'hFFFF);
  endtask

  task automatic test_collision();
    sstep = 4; c_deepest = 4'hF; tick();
    chk("R3 group of four", fways, 16'hF000);
    hold = 2; gstep = 2; intv = 1;
    fdone = 1; c_deepest = 0; tick(); fdone = 0;
    chk("R11 group disabled", way_en, 16'h0FFF);
    chk("R11 aborted", freq, 0);
    chk("R11 no sleep", psleep, 0);
    tick();
    c_deep = 4'b0001; tick(); c_deep = 0;
    chk("R8 restart", way_en, 16'h0FFF);
    tick();
    chk("R8 still counting", way_en, 16'h0FFF);
    tick();
    chk("R8 refill after restart", way_en, 16'h3FFF);
    tick();
    chk("R9 final step", way_en, 16'hFFFF);
  endtask

  task automatic test_reentry();
    sstep = 16; c_deepest = 4'hF; tick();
    chk("R3 whole cache", fways, 16'hFFFF);
    pulse_done();
    chk("R5 asleep", psleep, 1);
    hold = 20; c_deepest = 0; tick(); tick();
    chk("R6 awake empty", way_en, 16'h0000);
    c_deepest = 4'hF; tick();
    chk("R12 direct sleep", psleep, 1);
    chk("R12 no flush", freq, 0);
    hold = 1; gstep = 4; intv = 50;
    c_deepest = 0; tick(); tick();
    chk("R7 one cycle hold", way_en, 16'h000F);
    sstep = 3; c_deepest = 4'hF; tick();
    chk("R12 partial drain", freq, 1);
    chk("R12 partial group", fways, 16'h000E);
    pulse_done();
    chk("R12 one left", fways, 16'h0001);
    pulse_done();
    chk("R12 asleep", psleep, 1);
    gstep = 16; c_deepest = 0; tick(); tick();
    chk("R9 full refill", way_en, 16'hFFFF);
    chk("R9 idle", freq, 0);
  endtask

  initial begin
    rst_n = 0; c_deepest = 0; c_deep = 0; wake = 0; fdone = 0;
    sstep = 1; gstep = 1; hold = 1; intv = 1;
    repeat (3) tick();
    rst_n = 1; tick();
    test_reset();
    test_drain_and_refill();
    test_abort();
    test_collision();
    test_reentry();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule